// File: doc/BRIEF.md
# Masked Bus Address Watchpoint with Trace Freeze and Break Delay

This block watches every transfer on a 32-bit system bus and compares its address with a set of programmed watchpoints. Each watchpoint holds an address pattern, a bit mask and a control word. The control word enables the watchpoint and chooses whether reads, writes or both can trigger it. The comparison works on whole 32-bit words: address bits 1 and 0 take no part in it, so a byte access anywhere inside a watched word still hits.

On a hit, the block records which watchpoints matched and freezes the attached trace recorder. A global break-delay value decides what follows. A delay of zero freezes the trace at once and leaves the processor running. A delay of N greater than zero lets the trace record N more valid transfers, then freezes it and requests a processor halt in the same cycle. The hit status, freeze and halt request stay set until the next configuration write, which clears them and re-arms the unit. Software sets up the block through a simple register-write port.

Top module: `bus_watch_unit`

## Requirements
- R1: A mask bit of 1 requires the address bit to equal the pattern bit. A mask bit of 0 makes that address bit don't-care.
- R2: Address bits 1 and 0 are never compared, so all four byte addresses of a watched word match.
- R3: Control bit 1 allows a read (bus_write=0) to trigger, and control bit 2 allows a write (bus_write=1) to trigger. A transfer whose direction is not allowed never matches.
- R4: A watchpoint whose control bit 0 (enable) is 0 never matches.
- R5: Only transfers with bus_valid high are compared. An invalid cycle neither hits nor advances the break-delay count.
- R6: hit_status bit i goes high one clock after the sampled transfer that matches watchpoint i. Every watchpoint that matches that transfer sets its own bit.
- R7: With a break delay of 0, trace_freeze rises in the same cycle as hit_status, and halt_req stays low.
- R8: With a break delay N>0, trace_freeze and halt_req both rise together in the clock after the N-th valid transfer that follows the hit transfer. They stay low before that.
- R9: hit_status, trace_freeze and halt_req are sticky. Further matching transfers during the delay count or after the freeze change none of them.
- R10: Any configuration write clears hit_status, trace_freeze and halt_req and re-arms the unit for the next hit.
- R11: cfg_sel selects the register written at cfg_idx: 0 is the pattern, 1 is the mask, 2 is the control word (bit 0 enable, bit 1 read, bit 2 write). Selector 3 writes the global break delay from the low DLY_W bits of cfg_wdata, and ignores the upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register selector (pattern, mask, control, break delay) |
| cfg_idx | input | IDX_W | Watchpoint index for a per-watchpoint register |
| cfg_wdata | input | 32 | Configuration write data |
| bus_valid | input | 1 | A bus transfer is present this cycle |
| bus_addr | input | 32 | Transfer address |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| trace_freeze | output | 1 | Stops the trace recorder |
| halt_req | output | 1 | Halt request to the processor |
| hit_status | output | NUM_WP | Sticky per-watchpoint hit flags |

## Verification
The bench builds the unit with two watchpoints and a 4-bit break delay. With these settings, every mask bit position, every byte offset, and every combination of enable, read permission, write permission and direction can be swept, and the expected match is computed from the pattern and mask. Break delays 0 through 5 are each run past their end point, with idle cycles mixed in. This shows that only valid transfers count and that matches during the count change nothing. The 4-bit delay also lets a write with only an upper bit set show that the upper bits are discarded.

// File: rtl/bwu_pkg.sv
package bwu_pkg;
   typedef enum logic [1:0] {
      ST_ARMED  = 2'd0,
      ST_COUNT  = 2'd1,
      ST_FROZEN = 2'd2
   } bwu_state_e;

   localparam logic [1:0] SEL_PATTERN = 2'd0;
   localparam logic [1:0] SEL_MASK    = 2'd1;
   localparam logic [1:0] SEL_CTRL    = 2'd2;
   localparam logic [1:0] SEL_DELAY   = 2'd3;

   localparam int CTRL_EN_BIT = 0;
   localparam int CTRL_RD_BIT = 1;
   localparam int CTRL_WR_BIT = 2;
   localparam int CTRL_W      = 3;

   typedef struct packed {
      logic wr_ok;
      logic rd_ok;
      logic en;
   } bwu_ctrl_t;
endpackage

// File: rtl/bwu_comparator.sv
module bwu_comparator
   import bwu_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int WORD_LSB = 2
) (
   input  logic              bus_valid,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] pattern,
   input  logic [ADDR_W-1:0] mask,
   input  bwu_ctrl_t         ctrl,
   output logic              match
);
   localparam logic [ADDR_W-1:0] WORD_KEEP = {{(ADDR_W-WORD_LSB){1'b1}}, {WORD_LSB{1'b0}}};

   logic [ADDR_W-1:0] diff;
   logic              addr_hit;
   logic              dir_ok;

   generate
      if (WORD_LSB == 0) begin : g_byte_gran
         assign diff = (bus_addr ^ pattern) & mask;
      end else begin : g_word_gran
         assign diff = (bus_addr ^ pattern) & mask & WORD_KEEP;
      end
   endgenerate

   assign addr_hit = (diff == '0);
   assign dir_ok   = bus_write ? ctrl.wr_ok : ctrl.rd_ok;
   assign match    = bus_valid & ctrl.en & dir_ok & addr_hit;
endmodule

// File: rtl/bwu_trigger_ctrl.sv
module bwu_trigger_ctrl
   import bwu_pkg::*;
#(
   parameter int NUM_WP = 2,
   parameter int DLY_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              bus_valid,
   input  logic [NUM_WP-1:0] match_vec,
   input  logic [DLY_W-1:0]  break_dly,
   output logic [NUM_WP-1:0] hit_status,
   output logic              freeze,
   output logic              halt,
   output logic              armed
);
   bwu_state_e       state;
   logic [DLY_W-1:0] cnt;

   assign armed = (state == ST_ARMED);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_ARMED;
         cnt        <= '0;
         hit_status <= '0;
         freeze     <= 1'b0;
         halt       <= 1'b0;
      end else if (clear) begin
         state      <= ST_ARMED;
         cnt        <= '0;
         hit_status <= '0;
         freeze     <= 1'b0;
         halt       <= 1'b0;
      end else begin
         case (state)
            ST_ARMED: begin
               if (|match_vec) begin
                  hit_status <= match_vec;
                  if (break_dly == '0) begin
                     freeze <= 1'b1;
                     state  <= ST_FROZEN;
                  end else begin
                     cnt   <= break_dly;
                     state <= ST_COUNT;
                  end
               end
            end
            ST_COUNT: begin
               if (bus_valid) begin
                  cnt <= cnt - 1'b1;
                  if (cnt == DLY_W'(1)) begin
                     freeze <= 1'b1;
                     halt   <= 1'b1;
                     state  <= ST_FROZEN;
                  end
               end
            end
            default: state <= ST_FROZEN;
         endcase
      end
   end

   assert_halt_implies_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
      halt |-> freeze);
   assert_zero_delay_no_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(freeze) && break_dly == '0) |-> !halt);
   assert_sticky_after_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && !clear) |=> (freeze && $stable(hit_status) && $stable(halt)));
   assert_clear_rearms_R10: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (!freeze && !halt && hit_status == '0 && armed));
endmodule

// File: rtl/bus_watch_unit.sv
module bus_watch_unit
   import bwu_pkg::*;
#(
   parameter int NUM_WP = 4,
   parameter int DLY_W  = 8,
   parameter int IDX_W  = (NUM_WP > 1) ? $clog2(NUM_WP) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [31:0]       cfg_wdata,
   input  logic              bus_valid,
   input  logic [31:0]       bus_addr,
   input  logic              bus_write,
   output logic              trace_freeze,
   output logic              halt_req,
   output logic [NUM_WP-1:0] hit_status
);
   localparam int ADDR_W   = 32;
   localparam int WORD_LSB = 2;

   generate
      if (NUM_WP < 1 || NUM_WP > 64) begin : g_bad_num
         $error("bus_watch_unit: NUM_WP out of range");
      end
      if (DLY_W < 1 || DLY_W > 32) begin : g_bad_dly
         $error("bus_watch_unit: DLY_W out of range");
      end
      if ((1 << IDX_W) < NUM_WP) begin : g_bad_idx
         $error("bus_watch_unit: IDX_W too narrow");
      end
   endgenerate

   logic [ADDR_W-1:0] pat_q  [NUM_WP];
   logic [ADDR_W-1:0] mask_q [NUM_WP];
   bwu_ctrl_t         ctrl_q [NUM_WP];
   logic [DLY_W-1:0]  dly_q;
   logic [NUM_WP-1:0] match_vec;
   logic              armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dly_q <= '0;
      else if (cfg_we && cfg_sel == SEL_DELAY) dly_q <= cfg_wdata[DLY_W-1:0];
   end

   genvar gi;
   generate
      for (gi = 0; gi < NUM_WP; gi++) begin : g_wp
         logic sel_me;
         assign sel_me = cfg_we && (cfg_idx == IDX_W'(gi));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pat_q[gi]  <= '0;
               mask_q[gi] <= '0;
               ctrl_q[gi] <= '0;
            end else if (sel_me) begin
               case (cfg_sel)
                  SEL_PATTERN: pat_q[gi]  <= cfg_wdata;
                  SEL_MASK:    mask_q[gi] <= cfg_wdata;
                  SEL_CTRL:    ctrl_q[gi] <= bwu_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
                  default: ;
               endcase
            end
         end

         bwu_comparator #(
            .ADDR_W  (ADDR_W),
            .WORD_LSB(WORD_LSB)
         ) u_cmp (
            .bus_valid(bus_valid),
            .bus_addr (bus_addr),
            .bus_write(bus_write),
            .pattern  (pat_q[gi]),
            .mask     (mask_q[gi]),
            .ctrl     (ctrl_q[gi]),
            .match    (match_vec[gi])
         );
      end
   endgenerate

   bwu_trigger_ctrl #(
      .NUM_WP(NUM_WP),
      .DLY_W (DLY_W)
   ) u_trig (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (cfg_we),
      .bus_valid (bus_valid),
      .match_vec (match_vec),
      .break_dly (dly_q),
      .hit_status(hit_status),
      .freeze    (trace_freeze),
      .halt      (halt_req),
      .armed     (armed)
   );

   assert_hit_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !cfg_we && |match_vec) |=> (hit_status == $past(match_vec)));
   assert_invalid_no_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !cfg_we && !bus_valid) |=> (hit_status == '0 && !trace_freeze));
endmodule

// File: tb/bus_watch_unit_bench.sv
module bus_watch_unit_bench;
   localparam int NWP   = 2;
   localparam int DW    = 4;
   localparam int IW    = 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [1:0]    cfg_sel = '0;
   logic [IW-1:0] cfg_idx = '0;
   logic [31:0]   cfg_wdata = '0;
   logic          bus_valid = 1'b0;
   logic [31:0]   bus_addr = '0;
   logic          bus_write = 1'b0;
   logic          trace_freeze;
   logic          halt_req;
   logic [NWP-1:0] hit_status;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   bus_watch_unit #(.NUM_WP(NWP), .DLY_W(DW), .IDX_W(IW)) u_bus_watch_unit (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
      .cfg_wdata(cfg_wdata), .bus_valid(bus_valid), .bus_addr(bus_addr),
      .bus_write(bus_write), .trace_freeze(trace_freeze), .halt_req(halt_req),
      .hit_status(hit_status));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cfg(input logic [1:0] sel, input int idx, input logic [31:0] d);
      cfg_we = 1'b1; cfg_sel = sel; cfg_idx = IW'(idx); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic xfer(input logic [31:0] a, input logic w);
      bus_valid = 1'b1; bus_addr = a; bus_write = w;
      @(negedge clk);
      bus_valid = 1'b0;
   endtask

   task automatic setup_wp(input int idx, input logic [31:0] p, input logic [31:0] m,
                           input logic [2:0] c);
      cfg(2'd0, idx, p);
      cfg(2'd1, idx, m);
      cfg(2'd2, idx, {29'd0, c});
   endtask

   localparam logic [31:0] PA = 32'h5A3C_81F0;
   localparam logic [31:0] PB = 32'h1234_5670;
   localparam logic [31:0] MSK = 32'hF0F3_5A0F;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 reset freeze", {31'd0, trace_freeze}, 0);
      chk("R10 reset halt", {31'd0, halt_req}, 0);
      chk("R10 reset status", {30'd0, hit_status}, 0);

      // R11: selector 3 keeps only the low DLY_W bits (0x10 -> 0)
      cfg(2'd3, 0, 32'h10);
      setup_wp(1, PB, 32'h0, 3'b000);
      setup_wp(0, PA, MSK, 3'b111);

      // R1: flip each compared bit in turn
      for (int b = 2; b < 32; b++) begin
         logic exp_m;
         cfg(2'd3, 0, 32'h10);
         exp_m = !MSK[b];
         xfer(PA ^ (32'd1 << b), 1'b0);
         chk($sformatf("R1 mask bit %0d status", b), {30'd0, hit_status}, {31'd0, exp_m});
         chk($sformatf("R11 R7 bit %0d freeze", b), {31'd0, trace_freeze}, {31'd0, exp_m});
         chk("R7 no halt", {31'd0, halt_req}, 0);
      end

      // R2: byte offsets and low bits with a full mask
      cfg(2'd1, 0, 32'hFFFF_FFFF);
      for (int off = 0; off < 4; off++) begin
         cfg(2'd3, 0, 0);
         xfer(PA | 32'(off), 1'b1);
         chk($sformatf("R2 byte offset %0d", off), {30'd0, hit_status}, 1);
      end
      cfg(2'd3, 0, 0);
      xfer(PA ^ 32'h4, 1'b1);
      chk("R2 bit2 still compared", {30'd0, hit_status}, 0);

      // R3/R4: enable, read, write permission against direction
      for (int c = 0; c < 8; c++) begin
         for (int dir = 0; dir < 2; dir++) begin
            logic exp_m;
            cfg(2'd2, 0, 32'(c));
            exp_m = c[0] && (dir == 1 ? c[2] : c[1]);
            xfer(PA, dir[0]);
            chk($sformatf("R3 R4 ctrl %0d dir %0d", c, dir), {30'd0, hit_status}, {31'd0, exp_m});
         end
      end

      // R5: invalid cycle with a matching address
      cfg(2'd2, 0, 32'h7);
      bus_valid = 1'b0; bus_addr = PA; bus_write = 1'b0;
      @(negedge clk);
      chk("R5 invalid no hit", {30'd0, hit_status}, 0);
      chk("R5 invalid no freeze", {31'd0, trace_freeze}, 0);

      // R6: per-watchpoint status, one clock after
      setup_wp(1, PB, 32'hFFFF_FFFC, 3'b111);
      bus_valid = 1'b1; bus_addr = PB; bus_write = 1'b0;
      #1 chk("R6 not before edge", {30'd0, hit_status}, 0);
      @(negedge clk); bus_valid = 1'b0;
      chk("R6 wp1 only", {30'd0, hit_status}, 2);
      cfg(2'd1, 1, 32'h0);
      xfer(PA, 1'b0);
      chk("R6 both match", {30'd0, hit_status}, 3);
      cfg(2'd1, 1, 32'hFFFF_FFFC);

      // R7/R8/R9: break delay sweep
      for (int d = 0; d < 6; d++) begin
         cfg(2'd3, 0, 32'(d));
         xfer(PA, 1'b1);
         chk($sformatf("R8 d%0d hit status", d), {30'd0, hit_status}, 1);
         chk($sformatf("R7 R8 d%0d freeze at hit", d), {31'd0, trace_freeze}, {31'd0, d == 0});
         chk($sformatf("R7 R8 d%0d halt at hit", d), {31'd0, halt_req}, 0);
         for (int k = 1; k <= d + 2; k++) begin
            @(negedge clk);
            chk($sformatf("R5 d%0d idle k%0d", d, k), {31'd0, trace_freeze}, {31'd0, (k - 1) >= d});
            xfer((k % 2) ? PB : PA, 1'b0);
            chk($sformatf("R8 d%0d k%0d freeze", d, k), {31'd0, trace_freeze}, {31'd0, k >= d});
            chk($sformatf("R8 d%0d k%0d halt", d, k), {31'd0, halt_req}, {31'd0, d > 0 && k >= d});
            chk($sformatf("R9 d%0d k%0d status", d, k), {30'd0, hit_status}, 1);
         end
      end

      // R10: config write clears, then a fresh hit works
      cfg(2'd3, 0, 32'd2);
      chk("R10 cleared freeze", {31'd0, trace_freeze}, 0);
      chk("R10 cleared halt", {31'd0, halt_req}, 0);
      chk("R10 cleared status", {30'd0, hit_status}, 0);
      xfer(PB, 1'b1);
      chk("R10 rearmed", {30'd0, hit_status}, 2);
      xfer(PA, 1'b1);
      xfer(PA, 1'b1);
      chk("R8 halt after two", {31'd0, halt_req}, 1);
      chk("R9 status kept", {30'd0, hit_status}, 2);
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule